// File: doc/BRIEF.md
# Speculative Load Ordering Checker

This block is the load side of a memory-ordering unit in an out-of-order core that lets loads read the data cache before every older store has resolved its address. Each load takes a slot at the tail of a circular queue when it is dispatched, and the slot records the load's program-order age. The load's address is written into that slot when address generation completes. The slot is marked as performed once the load has read the cache. The oldest slot is released when the load retires.

When a store retires and writes the cache, the core presents the store's age and address to the block. The block compares them against every slot at once. A slot counts as a hit only if it holds a load that is younger than the store, has a known address equal to the store's address, and has already performed. Such a load has read stale data. One cycle later the block raises a flush request that carries the age of the oldest hit. The core then discards that load and everything after it and fetches again from that point.

When the core squashes instructions, it drives a squash request with an age. The block drops every load of that age or younger and rewinds its tail, so the next allocation reuses the freed slots. Ages wrap modulo 2^AGE_W and are compared over half the range. The queue depth must be a power of two.

Top module: `lqv_load_queue`

## Requirements
- R1: After reset the queue is empty, `lq_full` and `flush_valid` are 0, and `alloc_idx` is 0.
- R2: An accepted allocation fills the slot shown on `alloc_idx`, and `alloc_idx` then advances by one modulo DEPTH. `lq_full` goes to 1 when DEPTH loads are held. An allocation request while `lq_full` is 1 is ignored and leaves `alloc_idx` unchanged.
- R3: A retire request frees the head slot. When a retire and an accepted allocation occur in the same cycle, the occupancy is unchanged. An allocation is accepted only if the queue was not full at the start of that cycle.
- R4: If a store check finds a younger performed load at the same address, `flush_valid` is 1 in the cycle after the check and `flush_age` gives that load's age. `flush_valid` is 0 in any cycle that does not follow a store check.
- R5: The following loads never cause a flush: a load whose age equals the store's age or is older, a load without an address, a load that has not performed, and a load whose address differs from the store's.
- R6: If several loads hit, `flush_age` reports the one closest to the queue head, which is the oldest in program order.
- R7: A store check uses the flags as they stood at the start of its cycle. A load marked performed in the same cycle as the check does not hit. The same load is caught by a later check.
- R8: A squash with age A removes every load whose age is A or younger, and sets `alloc_idx` to head plus the number of surviving loads. A removed load never hits a later store check. An allocation request in a squash cycle is ignored.
- R9: Ages are compared modulo 2^AGE_W. Load age L is younger than store age S when (L − S) mod 2^AGE_W lies in the range 1 to 2^(AGE_W−1)−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Allocate a load at the tail |
| alloc_age | input | AGE_W | Program-order age of the allocated load |
| alloc_idx | output | log2(DEPTH) | Slot the next allocation will use |
| lq_full | output | 1 | All DEPTH slots are occupied |
| agen_valid | input | 1 | Write an address into a slot |
| agen_idx | input | log2(DEPTH) | Slot that receives the address |
| agen_addr | input | ADDR_W | Load address |
| perf_valid | input | 1 | Mark a slot as having read the cache |
| perf_idx | input | log2(DEPTH) | Slot to mark |
| retire_valid | input | 1 | Free the head slot |
| st_valid | input | 1 | Retiring store to check |
| st_age | input | AGE_W | Store age |
| st_addr | input | ADDR_W | Store address |
| squash_valid | input | 1 | Remove loads of an age and younger |
| squash_age | input | AGE_W | Oldest age to remove |
| flush_valid | output | 1 | Ordering violation found |
| flush_age | output | AGE_W | Age of the oldest violating load |

## Verification
The concurrency that matters most is a store check landing in the same cycle as a load being marked performed. The bench first gives a slot an address. In a later cycle it drives that slot's perform strobe and a matching older store on the same clock edge, and expects no flush. It then repeats the store alone and expects a flush naming that load. A second coincidence is tested too: allocation and retirement in the same cycle, once with the queue full, where the allocation is refused, and once with one free slot, where the occupancy holds. Each outcome is read from `lq_full` and `alloc_idx`.

// File: rtl/lqv_pkg.sv
package lqv_pkg;
    typedef struct packed {
        logic valid;
        logic addr_ok;
        logic done;
    } lq_flags_t;
endpackage

// File: rtl/lqv_match.sv
module lqv_match
    import lqv_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int AGE_W  = 6,
    parameter int ADDR_W = 16
) (
    input  lq_flags_t [DEPTH-1:0]             flags,
    input  logic      [DEPTH-1:0][AGE_W-1:0]  ages,
    input  logic      [DEPTH-1:0][ADDR_W-1:0] addrs,
    input  logic      [AGE_W-1:0]             probe_age,
    input  logic      [ADDR_W-1:0]            probe_addr,
    output logic      [DEPTH-1:0]             hit
);
    // One comparator per slot; a slot hits when it is a younger performed load at the probe address.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [AGE_W-1:0] diff;
        logic             younger;
        assign diff    = ages[g] - probe_age;
        assign younger = (diff != '0) && !diff[AGE_W-1];
        assign hit[g]  = flags[g].valid && flags[g].addr_ok && flags[g].done
                         && (addrs[g] == probe_addr) && younger;
    end
endmodule

// File: rtl/lqv_oldest_pick.sv
module lqv_oldest_pick #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [DEPTH-1:0] hit,
    input  logic [IDX_W-1:0] head,
    output logic             any,
    output logic [IDX_W-1:0] sel
);
    // Scan outward from the head; the first hit is the oldest in program order.
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [IDX_W-1:0] idx;
            idx = head + IDX_W'(k);
            if (hit[idx] && !any) begin
                any = 1'b1;
                sel = idx;
            end
        end
    end
endmodule

// File: rtl/lqv_load_queue.sv
module lqv_load_queue
    import lqv_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int AGE_W  = 6,
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [AGE_W-1:0]  alloc_age,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic              lq_full,
    input  logic              agen_valid,
    input  logic [IDX_W-1:0]  agen_idx,
    input  logic [ADDR_W-1:0] agen_addr,
    input  logic              perf_valid,
    input  logic [IDX_W-1:0]  perf_idx,
    input  logic              retire_valid,
    input  logic              st_valid,
    input  logic [AGE_W-1:0]  st_age,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              squash_valid,
    input  logic [AGE_W-1:0]  squash_age,
    output logic              flush_valid,
    output logic [AGE_W-1:0]  flush_age
);
    typedef struct packed {
        lq_flags_t [DEPTH-1:0]             flg;
        logic      [DEPTH-1:0][AGE_W-1:0]  age;
        logic      [DEPTH-1:0][ADDR_W-1:0] addr;
        logic      [IDX_W-1:0]             head;
        logic      [IDX_W-1:0]             tail;
        logic      [CNT_W-1:0]             count;
        logic                              fl_v;
        logic      [AGE_W-1:0]             fl_age;
    } state_t;

    state_t q, d;

    logic [DEPTH-1:0] hit;
    logic             hit_any;
    logic [IDX_W-1:0] hit_sel;

    lqv_match #(.DEPTH(DEPTH), .AGE_W(AGE_W), .ADDR_W(ADDR_W)) u_match (
        .flags      (q.flg),
        .ages       (q.age),
        .addrs      (q.addr),
        .probe_age  (st_age),
        .probe_addr (st_addr),
        .hit        (hit)
    );

    lqv_oldest_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
        .hit  (hit),
        .head (q.head),
        .any  (hit_any),
        .sel  (hit_sel)
    );

    logic [DEPTH-1:0] kill;
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic [AGE_W-1:0] sd;
            sd      = q.age[i] - squash_age;
            kill[i] = !sd[AGE_W-1];
        end
    end

    always_comb begin
        logic [CNT_W-1:0] keep;
        d    = q;
        keep = '0;
        // Retirement frees the head.
        if (retire_valid && (q.count != '0)) begin
            d.flg[q.head] = '0;
            d.head        = q.head + IDX_W'(1);
            d.count       = q.count - CNT_W'(1);
        end
        // Address generation fills the address field.
        if (agen_valid && d.flg[agen_idx].valid) begin
            d.addr[agen_idx]        = agen_addr;
            d.flg[agen_idx].addr_ok = 1'b1;
        end
        // Cache access marks the load performed.
        if (perf_valid && d.flg[perf_idx].valid && d.flg[perf_idx].addr_ok) begin
            d.flg[perf_idx].done = 1'b1;
        end
        // Allocation at the tail; refused when full at cycle start or during a squash.
        if (alloc_valid && !squash_valid && (q.count != CNT_W'(DEPTH))) begin
            d.flg[q.tail] = '{valid: 1'b1, addr_ok: 1'b0, done: 1'b0};
            d.age[q.tail] = alloc_age;
            d.tail        = q.tail + IDX_W'(1);
            d.count       = d.count + CNT_W'(1);
        end
        // Squash removes the given age and younger, then rewinds the tail.
        if (squash_valid) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (d.flg[i].valid && kill[i]) d.flg[i] = '0;
                keep = keep + CNT_W'(d.flg[i].valid);
            end
            d.count = keep;
            d.tail  = d.head + IDX_W'(keep);
        end
        // Store check result, registered.
        d.fl_v   = st_valid && hit_any;
        d.fl_age = (st_valid && hit_any) ? q.age[hit_sel] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign alloc_idx   = q.tail;
    assign lq_full     = (q.count == CNT_W'(DEPTH));
    assign flush_valid = q.fl_v;
    assign flush_age   = q.fl_age;
endmodule

// File: rtl/lqv_checker.sv
module lqv_checker #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic [IDX_W-1:0] alloc_idx,
    input logic             lq_full,
    input logic             retire_valid,
    input logic             squash_valid,
    input logic             st_valid,
    input logic             flush_valid
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!flush_valid && !lq_full));

    a_r2_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_full && alloc_valid && !retire_valid && !squash_valid) |=> (lq_full && $stable(alloc_idx)));

    a_r2_alloc_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !lq_full && !squash_valid) |=> (alloc_idx == $past(alloc_idx) + IDX_W'(1)));

    a_r4_flush_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> !flush_valid);

    a_r8_squash_no_full: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid && !lq_full) |=> !lq_full);
endmodule

bind lqv_load_queue lqv_checker #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_idx    (alloc_idx),
    .lq_full      (lq_full),
    .retire_valid (retire_valid),
    .squash_valid (squash_valid),
    .st_valid     (st_valid),
    .flush_valid  (flush_valid)
);

// File: tb/lqv_load_queue_tb.sv
module lqv_load_queue_tb;
    localparam int DEPTH  = 8;
    localparam int AGE_W  = 6;
    localparam int ADDR_W = 16;
    localparam int IDX_W  = 3;
    localparam int NV     = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic [AGE_W-1:0]  alloc_age = '0;
    logic [IDX_W-1:0]  alloc_idx;
    logic              lq_full;
    logic              agen_valid = 1'b0;
    logic [IDX_W-1:0]  agen_idx = '0;
    logic [ADDR_W-1:0] agen_addr = '0;
    logic              perf_valid = 1'b0;
    logic [IDX_W-1:0]  perf_idx = '0;
    logic              retire_valid = 1'b0;
    logic              st_valid = 1'b0;
    logic [AGE_W-1:0]  st_age = '0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic              squash_valid = 1'b0;
    logic [AGE_W-1:0]  squash_age = '0;
    logic              flush_valid;
    logic [AGE_W-1:0]  flush_age;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    lqv_load_queue #(.DEPTH(DEPTH), .AGE_W(AGE_W), .ADDR_W(ADDR_W)) u_dut (.*);

    // Store vectors against loads aged 10..15: 10@0x100 P, 11@0x200 P, 12@0x100 unperformed,
    // 13@0x300 P, 14@0x100 P, 15 no address.
    localparam logic [AGE_W-1:0]  V_AGE  [NV] = '{6'd9, 6'd10, 6'd11, 6'd14, 6'd12, 6'd13, 6'd9, 6'd11, 6'd5, 6'd50, 6'd20};
    localparam logic [ADDR_W-1:0] V_ADDR [NV] = '{16'h100, 16'h100, 16'h100, 16'h100, 16'h300, 16'h300,
                                                  16'h400, 16'h200, 16'h200, 16'h100, 16'h100};
    localparam logic              V_EXPV [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [AGE_W-1:0]  V_EXPA [NV] = '{6'd10, 6'd14, 6'd14, 6'd0, 6'd13, 6'd0, 6'd0, 6'd0, 6'd11, 6'd10, 6'd0};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_alloc(input logic [AGE_W-1:0] a, input logic ret);
        alloc_valid = 1'b1; alloc_age = a; retire_valid = ret;
        tick();
        alloc_valid = 1'b0; retire_valid = 1'b0;
    endtask

    task automatic do_agen(input logic [IDX_W-1:0] i, input logic [ADDR_W-1:0] ad);
        agen_valid = 1'b1; agen_idx = i; agen_addr = ad;
        tick();
        agen_valid = 1'b0;
    endtask

    task automatic do_perf(input logic [IDX_W-1:0] i);
        perf_valid = 1'b1; perf_idx = i;
        tick();
        perf_valid = 1'b0;
    endtask

    task automatic do_store(input string req, input logic [AGE_W-1:0] a, input logic [ADDR_W-1:0] ad,
                            input logic ev, input logic [AGE_W-1:0] ea);
        st_valid = 1'b1; st_age = a; st_addr = ad;
        tick();
        st_valid = 1'b0; perf_valid = 1'b0;
        chk(req, {31'd0, flush_valid}, {31'd0, ev});
        if (ev) chk(req, {26'd0, flush_age}, {26'd0, ea});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 full", {31'd0, lq_full}, 32'd0);
        chk("R1 flush", {31'd0, flush_valid}, 32'd0);
        chk("R1 idx", {29'd0, alloc_idx}, 32'd0);

        for (int a = 10; a < 16; a++) do_alloc(AGE_W'(a), 1'b0);
        chk("R2 idx after six", {29'd0, alloc_idx}, 32'd6);
        do_agen(3'd0, 16'h100); do_agen(3'd1, 16'h200); do_agen(3'd2, 16'h100);
        do_agen(3'd3, 16'h300); do_agen(3'd4, 16'h100);
        do_perf(3'd0); do_perf(3'd1); do_perf(3'd3); do_perf(3'd4);
        do_perf(3'd5); // no address: ignored (R5)

        // Table walk: R4, R5, R6, R9
        for (int v = 0; v < NV; v++) begin
            do_store($sformatf("R4/R5/R6/R9 vec%0d", v), V_AGE[v], V_ADDR[v], V_EXPV[v], V_EXPA[v]);
        end

        // R7: perform in the same cycle as the store check is not seen
        do_agen(3'd5, 16'h500);
        perf_valid = 1'b1; perf_idx = 3'd5;
        do_store("R7 same cycle", 6'd9, 16'h500, 1'b0, 6'd0);
        do_store("R7 later check", 6'd9, 16'h500, 1'b1, 6'd15);

        // R8: squash age 13 and younger
        squash_valid = 1'b1; squash_age = 6'd13;
        alloc_valid = 1'b1; alloc_age = 6'd40;
        tick();
        squash_valid = 1'b0; alloc_valid = 1'b0;
        chk("R8 tail rewound", {29'd0, alloc_idx}, 32'd3);
        do_store("R8 squashed gone", 6'd9, 16'h300, 1'b0, 6'd0);
        do_store("R8 survivor hit", 6'd9, 16'h100, 1'b1, 6'd10);

        // R2 / R3: fill, refuse, alloc+retire coincidence
        for (int a = 13; a < 18; a++) do_alloc(AGE_W'(a), 1'b0);
        chk("R2 full", {31'd0, lq_full}, 32'd1);
        chk("R2 idx wrap", {29'd0, alloc_idx}, 32'd0);
        do_alloc(6'd18, 1'b0);
        chk("R2 refused full", {31'd0, lq_full}, 32'd1);
        chk("R2 refused idx", {29'd0, alloc_idx}, 32'd0);
        do_alloc(6'd18, 1'b1);
        chk("R3 retire while full", {31'd0, lq_full}, 32'd0);
        chk("R3 alloc refused", {29'd0, alloc_idx}, 32'd0);
        do_alloc(6'd18, 1'b1);
        chk("R3 alloc+retire idx", {29'd0, alloc_idx}, 32'd1);
        chk("R3 alloc+retire level", {31'd0, lq_full}, 32'd0);
        do_alloc(6'd19, 1'b0);
        chk("R3 refill full", {31'd0, lq_full}, 32'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule